// File: doc/BRIEF.md
# Control Endpoint Status Sequencer

This block keeps the handshake and status state of a device's bidirectional control endpoint. It sits between two parties. One is an abstract bus-event interface that reports a received SETUP/OUT packet, a transmitted IN packet, a transmitted STALL handshake, and the end of a control transfer. The other is a byte-wide software status/control register. FIFO storage, serialisation, CRC and token decoding are handled elsewhere. The block drives the ready flags, the stall request, the data-stage end marker and the early-end flag. It also produces one interrupt pulse for the endpoint and a FIFO flush pulse.

The packet phase is a four-state machine.
- `PH_IDLE`: nothing is pending.
- `PH_HOLD_RX`: a received packet waits for software.
- `PH_ARMED_TX`: software has loaded a packet to send.
- `PH_STALL`: a STALL handshake is requested.

Its transitions are:
- `PH_IDLE -> PH_HOLD_RX` on a received packet.
- `PH_IDLE -> PH_STALL` on a send-stall write.
- `PH_IDLE -> PH_ARMED_TX` on a transmit-ready write.
- `PH_HOLD_RX -> PH_STALL` on a send-stall write.
- `PH_HOLD_RX -> PH_IDLE` on a clear-receive write.
- `PH_ARMED_TX -> PH_IDLE` when the packet has been sent.
- `PH_ARMED_TX -> PH_STALL` on a send-stall write.
- `PH_STALL -> PH_IDLE` when the handshake has gone out.
- Any state `-> PH_IDLE` when the transfer ends.

Within one cycle a bus event beats a software command. The sticky flags (stall-sent, data-end, early-end) sit beside the machine in their own register stage.

Top module: `ep0_status_seq`

## Requirements
- R1: After reset, and with all inputs quiet, the register reads 0x00 and `irq` and `fifo_flush` are low. Register bits from LSB up: 0 receive-ready, 1 transmit-ready, 2 stall-sent, 3 data-end, 4 early-end, 5 send-stall, 6 clear-receive command, 7 clear-early-end command.
- R2: A received packet in `PH_IDLE` sets bit 0 and pulses `irq` in the cycle after the event. A received packet while a packet is already held is ignored.
- R3: Writing 1 to bit 6 clears bit 0 without an interrupt, and bit 6 always reads 0.
- R4: Writing 1 to bit 1 sets transmit-ready. The packet-sent event clears it and pulses `irq`.
- R5: Writing 1 to bit 5 raises `stall_req`. The STALL-sent event clears it, sets bit 2 and pulses `irq`.
- R6: Bit 2 stays set until software writes the register with bit 2 at 0. Writing 1 to bit 2 has no effect.
- R7: Writing 1 to bit 3 sets data-end. A transfer-end event clears it, and when data-end was set that event raises neither `irq` nor `fifo_flush`.
- R8: A transfer-end event while data-end is 0 returns the phase to idle, sets bit 4, and pulses both `fifo_flush` and `irq`.
- R9: Bit 4 stays set through writes with bit 7 at 0. Writing 1 to bit 7 clears it, and bit 7 always reads 0.
- R10: `irq` is a one-cycle pulse, and several causes in the same cycle give a single pulse.
- R11: When a bus event and a phase-changing software command coincide, the bus event's transition is taken and the command is dropped.
- R12: While `usb_en` is low, all state is synchronously forced to zero and events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_en | input | 1 | Controller enable; low holds all state at zero |
| ev_rx_pkt | input | 1 | A packet has landed in the endpoint FIFO |
| ev_tx_sent | input | 1 | The armed IN packet has been transmitted |
| ev_stall_sent | input | 1 | A STALL handshake has been transmitted |
| ev_xfer_end | input | 1 | The control transfer has ended |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Status register readback |
| rx_ready | output | 1 | Received packet held for software |
| tx_ready | output | 1 | Packet armed for transmission |
| stall_req | output | 1 | STALL handshake requested |
| stall_sent | output | 1 | A STALL has been sent (sticky) |
| data_end | output | 1 | Data stage end marker |
| early_end | output | 1 | Transfer ended before data-end was marked (sticky) |
| irq | output | 1 | Endpoint interrupt pulse |
| fifo_flush | output | 1 | FIFO flush pulse |

## Verification
Some behaviours are checked by assertions on every cycle:
- the stickiness of the stall-sent and early-end flags;
- the forced return to idle on a transfer end;
- the sent-packet and STALL handshakes;
- the zeroing while disabled.

Other behaviours only show up in the bench's scenarios:
- the single interrupt pulse when a sent packet and an early end coincide;
- a dropped stall write that loses to a sent-packet event;
- the zero readback of the command bits;
- a second received packet being ignored.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

    localparam int REG_W       = 8;
    localparam int B_RX_RDY    = 0;
    localparam int B_TX_RDY    = 1;
    localparam int B_STALL_SNT = 2;
    localparam int B_DATA_END  = 3;
    localparam int B_EARLY     = 4;
    localparam int B_STALL_REQ = 5;
    localparam int B_CLR_RX    = 6;
    localparam int B_CLR_EARLY = 7;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_HOLD_RX  = 2'd1,
        PH_ARMED_TX = 2'd2,
        PH_STALL    = 2'd3
    } phase_e;

    typedef struct packed {
        logic set_tx;
        logic set_dend;
        logic set_stall;
        logic clr_rx;
        logic clr_early;
        logic clr_stall_sent;
    } sw_cmd_t;

endpackage

// File: rtl/ep0_cmd_decode.sv
module ep0_cmd_decode
    import ep0_seq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output sw_cmd_t      cmd
);

    always_comb begin
        cmd.set_tx         = wr &  wdata[B_TX_RDY];
        cmd.set_dend       = wr &  wdata[B_DATA_END];
        cmd.set_stall      = wr &  wdata[B_STALL_REQ];
        cmd.clr_rx         = wr &  wdata[B_CLR_RX];
        cmd.clr_early      = wr &  wdata[B_CLR_EARLY];
        cmd.clr_stall_sent = wr & ~wdata[B_STALL_SNT];
    end

endmodule

// File: rtl/ep0_phase_fsm.sv
module ep0_phase_fsm
    import ep0_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    usb_en,
    input  logic    ev_rx_pkt,
    input  logic    ev_tx_sent,
    input  logic    ev_stall_sent,
    input  logic    ev_xfer_end,
    input  sw_cmd_t cmd,
    output logic    rx_ready,
    output logic    tx_ready,
    output logic    stall_req,
    output logic    rx_got,
    output logic    tx_done,
    output logic    stall_done
);

    phase_e phase, phase_nxt;

    // Next-state: bus events are examined before software commands (R11).
    always_comb begin
        phase_nxt  = phase;
        rx_got     = 1'b0;
        tx_done    = 1'b0;
        stall_done = 1'b0;
        if (ev_xfer_end) begin
            phase_nxt = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (ev_rx_pkt) begin
                        phase_nxt = PH_HOLD_RX;
                        rx_got    = 1'b1;
                    end else if (cmd.set_stall) begin
                        phase_nxt = PH_STALL;
                    end else if (cmd.set_tx) begin
                        phase_nxt = PH_ARMED_TX;
                    end
                end
                PH_HOLD_RX: begin
                    if (cmd.set_stall)   phase_nxt = PH_STALL;
                    else if (cmd.clr_rx) phase_nxt = PH_IDLE;
                end
                PH_ARMED_TX: begin
                    if (ev_tx_sent) begin
                        phase_nxt = PH_IDLE;
                        tx_done   = 1'b1;
                    end else if (cmd.set_stall) begin
                        phase_nxt = PH_STALL;
                    end
                end
                PH_STALL: begin
                    if (ev_stall_sent) begin
                        phase_nxt  = PH_IDLE;
                        stall_done = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase <= PH_IDLE;
        else if (!usb_en) phase <= PH_IDLE;
        else              phase <= phase_nxt;
    end

    always_comb begin
        rx_ready  = (phase == PH_HOLD_RX);
        tx_ready  = (phase == PH_ARMED_TX);
        stall_req = (phase == PH_STALL);
    end

    a_r4_sent_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_en && phase == PH_ARMED_TX && ev_tx_sent) |=> phase == PH_IDLE);

    a_r8_end_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_en && ev_xfer_end) |=> phase == PH_IDLE);

    a_r11_rx_beats_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_en && phase == PH_IDLE && ev_rx_pkt && !ev_xfer_end) |=> phase == PH_HOLD_RX);

endmodule

// File: rtl/ep0_flag_regs.sv
module ep0_flag_regs
    import ep0_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    usb_en,
    input  logic    ev_xfer_end,
    input  sw_cmd_t cmd,
    input  logic    rx_got,
    input  logic    tx_done,
    input  logic    stall_done,
    output logic    stall_sent,
    output logic    data_end,
    output logic    early_end,
    output logic    irq,
    output logic    fifo_flush
);

    logic early_hit;
    assign early_hit = ev_xfer_end & ~data_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_sent <= 1'b0;
            data_end   <= 1'b0;
            early_end  <= 1'b0;
            irq        <= 1'b0;
            fifo_flush <= 1'b0;
        end else if (!usb_en) begin
            stall_sent <= 1'b0;
            data_end   <= 1'b0;
            early_end  <= 1'b0;
            irq        <= 1'b0;
            fifo_flush <= 1'b0;
        end else begin
            if (stall_done)              stall_sent <= 1'b1;
            else if (cmd.clr_stall_sent) stall_sent <= 1'b0;
            if (ev_xfer_end)             data_end   <= 1'b0;
            else if (cmd.set_dend)       data_end   <= 1'b1;
            if (early_hit)               early_end  <= 1'b1;
            else if (cmd.clr_early)      early_end  <= 1'b0;
            irq        <= rx_got | tx_done | stall_done | early_hit;
            fifo_flush <= early_hit;
        end
    end

    a_r6_stall_sent_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_en && stall_sent && !cmd.clr_stall_sent) |=> stall_sent);

    a_r9_early_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_en && early_end && !cmd.clr_early) |=> early_end);

    a_r7_end_clears_dend: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_en && ev_xfer_end) |=> !data_end);

endmodule

// File: rtl/ep0_status_seq.sv
module ep0_status_seq
    import ep0_seq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         usb_en,
    input  logic         ev_rx_pkt,
    input  logic         ev_tx_sent,
    input  logic         ev_stall_sent,
    input  logic         ev_xfer_end,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_wdata,
    output logic [W-1:0] sw_rdata,
    output logic         rx_ready,
    output logic         tx_ready,
    output logic         stall_req,
    output logic         stall_sent,
    output logic         data_end,
    output logic         early_end,
    output logic         irq,
    output logic         fifo_flush
);

    sw_cmd_t cmd;
    logic    rx_got, tx_done, stall_done;

    ep0_cmd_decode #(.W(W)) u_dec (
        .wr    (sw_wr),
        .wdata (sw_wdata),
        .cmd   (cmd)
    );

    ep0_phase_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .usb_en        (usb_en),
        .ev_rx_pkt     (ev_rx_pkt),
        .ev_tx_sent    (ev_tx_sent),
        .ev_stall_sent (ev_stall_sent),
        .ev_xfer_end   (ev_xfer_end),
        .cmd           (cmd),
        .rx_ready      (rx_ready),
        .tx_ready      (tx_ready),
        .stall_req     (stall_req),
        .rx_got        (rx_got),
        .tx_done       (tx_done),
        .stall_done    (stall_done)
    );

    ep0_flag_regs u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .usb_en      (usb_en),
        .ev_xfer_end (ev_xfer_end),
        .cmd         (cmd),
        .rx_got      (rx_got),
        .tx_done     (tx_done),
        .stall_done  (stall_done),
        .stall_sent  (stall_sent),
        .data_end    (data_end),
        .early_end   (early_end),
        .irq         (irq),
        .fifo_flush  (fifo_flush)
    );

    // Command bits (6, 7) and unused upper bits read back as zero (R3, R9).
    always_comb begin
        sw_rdata              = '0;
        sw_rdata[B_RX_RDY]    = rx_ready;
        sw_rdata[B_TX_RDY]    = tx_ready;
        sw_rdata[B_STALL_SNT] = stall_sent;
        sw_rdata[B_DATA_END]  = data_end;
        sw_rdata[B_EARLY]     = early_end;
        sw_rdata[B_STALL_REQ] = stall_req;
    end

    a_r12_disable_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_en |=> (sw_rdata == '0 && !irq && !fifo_flush));

    a_r5_stall_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_en && stall_req && ev_stall_sent && !ev_xfer_end) |=> (stall_sent && !stall_req && irq));

    a_r2_rx_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_en && !rx_ready && !tx_ready && !stall_req && ev_rx_pkt && !ev_xfer_end)
        |=> (rx_ready && irq));

endmodule

// File: tb/ep0_status_seq_tb.sv
`timescale 1ns/1ps
module ep0_status_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_en = 1'b0;
    logic       ev_rx_pkt = 1'b0, ev_tx_sent = 1'b0, ev_stall_sent = 1'b0, ev_xfer_end = 1'b0;
    logic       sw_wr = 1'b0;
    logic [7:0] sw_wdata = '0;
    logic [7:0] sw_rdata;
    logic       rx_ready, tx_ready, stall_req, stall_sent, data_end, early_end, irq, fifo_flush;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       irq;
        logic       fl;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #2.5 clk = ~clk;

    ep0_status_seq u_dut (
        .clk(clk), .rst_n(rst_n), .usb_en(usb_en),
        .ev_rx_pkt(ev_rx_pkt), .ev_tx_sent(ev_tx_sent),
        .ev_stall_sent(ev_stall_sent), .ev_xfer_end(ev_xfer_end),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .rx_ready(rx_ready), .tx_ready(tx_ready), .stall_req(stall_req),
        .stall_sent(stall_sent), .data_end(data_end), .early_end(early_end),
        .irq(irq), .fifo_flush(fifo_flush)
    );

    // Monitor: pops one expected item per cycle, away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            cur = exp_q.pop_front();
            checks++;
            if (sw_rdata !== cur.rd || irq !== cur.irq || fifo_flush !== cur.fl) begin
                failures++;
                $display("FAIL %s: rdata=%h irq=%b flush=%b expected rdata=%h irq=%b flush=%b",
                         cur.tag, sw_rdata, irq, fifo_flush, cur.rd, cur.irq, cur.fl);
            end
        end
    end

    // Driver: apply one cycle of stimulus, push the result expected after the edge.
    task automatic cyc(input logic en, input logic rx, input logic txs, input logic sts,
                       input logic xe, input logic wr, input logic [7:0] wd,
                       input logic [7:0] erd, input logic eirq, input logic efl,
                       input string tag);
        exp_t e;
        usb_en = en; ev_rx_pkt = rx; ev_tx_sent = txs; ev_stall_sent = sts;
        ev_xfer_end = xe; sw_wr = wr; sw_wdata = wd;
        @(posedge clk);
        e.rd = erd; e.irq = eirq; e.fl = efl; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //   en rx tx st xe wr wd     exp   irq fl
        cyc(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R1 reset state");
        cyc(1, 1, 0, 0, 0, 0, 8'h00, 8'h01, 1, 0, "R2 rx sets ready");
        cyc(1, 0, 0, 0, 0, 0, 8'h00, 8'h01, 0, 0, "R10 irq single cycle");
        cyc(1, 1, 0, 0, 0, 0, 8'h00, 8'h01, 0, 0, "R2 second rx ignored");
        cyc(1, 0, 0, 0, 0, 1, 8'h40, 8'h00, 0, 0, "R3 clear rx, bit6 reads 0");
        cyc(1, 0, 0, 0, 0, 1, 8'h02, 8'h02, 0, 0, "R4 tx ready set");
        cyc(1, 0, 0, 0, 0, 1, 8'h08, 8'h0A, 0, 0, "R7 data-end set");
        cyc(1, 0, 1, 0, 0, 0, 8'h00, 8'h08, 1, 0, "R4 tx sent clears with irq");
        cyc(1, 0, 0, 0, 1, 0, 8'h00, 8'h00, 0, 0, "R7 end with data-end: quiet clear");
        cyc(1, 0, 0, 0, 1, 0, 8'h00, 8'h10, 1, 1, "R8 early end flag flush irq");
        cyc(1, 0, 0, 0, 0, 1, 8'h00, 8'h10, 0, 0, "R9 early flag sticky");
        cyc(1, 0, 0, 0, 0, 1, 8'h80, 8'h00, 0, 0, "R9 early clear, bit7 reads 0");
        cyc(1, 0, 0, 0, 0, 1, 8'h20, 8'h20, 0, 0, "R5 stall request");
        cyc(1, 0, 0, 1, 0, 0, 8'h00, 8'h04, 1, 0, "R5 stall sent");
        cyc(1, 0, 0, 0, 0, 1, 8'h04, 8'h04, 0, 0, "R6 write 1 no effect");
        cyc(1, 0, 0, 0, 0, 1, 8'h00, 8'h00, 0, 0, "R6 write 0 clears");
        cyc(1, 0, 0, 0, 0, 1, 8'h02, 8'h02, 0, 0, "R10 arm tx");
        cyc(1, 0, 1, 0, 1, 0, 8'h00, 8'h10, 1, 1, "R10 two causes one pulse");
        cyc(1, 0, 0, 0, 0, 0, 8'h00, 8'h10, 0, 0, "R10 pulse ends");
        cyc(1, 0, 0, 0, 0, 1, 8'h80, 8'h00, 0, 0, "R9 clear early");
        cyc(1, 0, 0, 0, 0, 1, 8'h02, 8'h02, 0, 0, "R11 arm tx");
        cyc(1, 0, 1, 0, 0, 1, 8'h20, 8'h00, 1, 0, "R11 event beats stall write");
        cyc(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R11 stall dropped");
        cyc(1, 1, 0, 0, 0, 0, 8'h00, 8'h01, 1, 0, "R2 rx again");
        cyc(1, 0, 0, 0, 0, 1, 8'h08, 8'h09, 0, 0, "R7 data-end with rx held");
        cyc(0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R12 disable clears");
        cyc(0, 1, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R12 events ignored");
        cyc(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R12 re-enable idle");
        cyc(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R1 settle");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule